// File: doc/BRIEF.md
# Flash Operation FIFO Sequencer

This block runs software-requested flash operations one flash word at a time. Software gives an operation code, a partition bit, a start word address and a word count, then pulses a start strobe. A read operation fetches words from the flash back end and places each returned word in a read FIFO for software to drain. A program operation takes words that software has pushed into a program FIFO and sends them to the flash one beat at a time. Page erase and bank erase each issue a single request.

The word count may be far larger than either FIFO. A read pauses when the read FIFO holds as many words as a programmable fill level allows, and it raises an interrupt until software makes room. A program stalls whenever the program FIFO is empty, and it raises an interrupt asking for more data. Every request is held with a fixed address, command and data until the back end answers with a done pulse. An access-check error aborts the operation and is reported in status.

Top module: `flash_op_seq`

## Requirements
- R1: After reset, busy, operation-done, error, both interrupts and the flash request are low, and the read FIFO is empty.
- R2: A read with count field N (the field holds the number of words minus one) issues exactly N+1 read requests. The returned words reach the read FIFO output in the order they were returned.
- R3: A read issues no request while the read FIFO level is at or above the effective fill level. The effective fill level is the fill input, or the FIFO depth when the input is 0 or larger than the depth. The read-level interrupt is high while the read is paused for this reason. The read resumes once software pops a word.
- R4: A program sends the program FIFO words to the flash in push order. While the program FIFO is empty during a program, no request is issued and the program-empty interrupt is high.
- R5: Once a request is raised, the request, command lines, address and partition stay unchanged until the matching done pulse or an access error. For a program, the data also stays unchanged.
- R6: The first beat uses the start address, and the address increases by one word after each completed beat.
- R7: The last-beat flag is high only on the final program beat of an operation.
- R8: Operation-done goes high and busy goes low at the clock edge that samples the final done pulse. Both operation-done and error clear when the next start is accepted.
- R9: Operation codes: 0 read, 1 program, 2 page erase, 3 bank erase. Exactly one command line is high with each request. An erase completes after a single request, and the partition bit is forwarded with every request.
- R10: A start strobe while busy is ignored. The running operation keeps its command, addresses and count.
- R11: An access error sampled with a request ends the operation at that edge. The request drops, busy clears, and both error and operation-done are set. No word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for a new operation |
| op_i | input | 2 | Operation code (0 read, 1 program, 2 page erase, 3 bank erase) |
| part_i | input | 1 | Partition select: 0 data, 1 information |
| addr_i | input | AW | Start word address |
| nwords_i | input | CW | Number of words minus one |
| rd_lvl_i | input | LW | Read FIFO fill level at which reads pause |
| busy_o | output | 1 | Operation in progress |
| op_done_o | output | 1 | Operation finished (normally or by error) |
| op_err_o | output | 1 | Operation aborted by an access error |
| irq_rd_lvl_o | output | 1 | Read paused at the fill level |
| irq_prog_empty_o | output | 1 | Program stalled on an empty program FIFO |
| rf_pop_i | input | 1 | Software pop from read FIFO |
| rf_rdata_o | output | WW | Read FIFO head word |
| rf_empty_o | output | 1 | Read FIFO empty |
| rf_level_o | output | LW | Read FIFO occupancy |
| pf_push_i | input | 1 | Software push into program FIFO |
| pf_wdata_i | input | WW | Program FIFO push data |
| pf_full_o | output | 1 | Program FIFO full |
| fl_req_o | output | 1 | Flash request |
| fl_rd_o | output | 1 | Read command |
| fl_prog_o | output | 1 | Program command |
| fl_pg_erase_o | output | 1 | Page erase command |
| fl_bk_erase_o | output | 1 | Bank erase command |
| fl_part_o | output | 1 | Partition of the request |
| fl_addr_o | output | AW | Word address of the request |
| fl_prog_data_o | output | WW | Program data |
| fl_prog_last_o | output | 1 | Final program beat |
| fl_rd_done_i | input | 1 | Read done pulse |
| fl_prog_done_i | input | 1 | Program done pulse |
| fl_erase_done_i | input | 1 | Erase done pulse |
| fl_rd_data_i | input | WW | Read data, valid with read done |
| acc_err_i | input | 1 | Access checker denies the current request |

## Verification
A start strobe sampled at one rising edge sets busy at that edge, and the first request rises at the next edge. A done or error pulse sampled at an edge drops the request, stores the word, advances the address and, on the final beat, sets operation-done at that same edge. The next request follows one edge later. The bench drives every input and samples every output on falling edges, so each result is observed half a cycle after the edge that produced it. The responder is a scoreboard. It compares each request's address, partition, data and last flag with its queues, and it holds its done pulse back for a set latency so that the hold-stable checks cover several cycles.

// File: rtl/flash_op_seq.sv
module flash_op_seq #(
  parameter int AW    = 16,
  parameter int WW    = 32,
  parameter int CW    = 12,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          part_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] nwords_i,
  input  logic [LW-1:0] rd_lvl_i,
  output logic          busy_o,
  output logic          op_done_o,
  output logic          op_err_o,
  output logic          irq_rd_lvl_o,
  output logic          irq_prog_empty_o,
  input  logic          rf_pop_i,
  output logic [WW-1:0] rf_rdata_o,
  output logic          rf_empty_o,
  output logic [LW-1:0] rf_level_o,
  input  logic          pf_push_i,
  input  logic [WW-1:0] pf_wdata_i,
  output logic          pf_full_o,
  output logic          fl_req_o,
  output logic          fl_rd_o,
  output logic          fl_prog_o,
  output logic          fl_pg_erase_o,
  output logic          fl_bk_erase_o,
  output logic          fl_part_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [WW-1:0] fl_prog_data_o,
  output logic          fl_prog_last_o,
  input  logic          fl_rd_done_i,
  input  logic          fl_prog_done_i,
  input  logic          fl_erase_done_i,
  input  logic [WW-1:0] fl_rd_data_i,
  input  logic          acc_err_i
);

  typedef enum logic [1:0] {OP_RD = 2'd0, OP_PG = 2'd1, OP_PE = 2'd2, OP_BE = 2'd3} op_e;

  op_e           op_q;
  logic          busy_q, req_q, done_q, err_q, part_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;

  logic [WW-1:0] rf_mem [DEPTH];
  logic [PW-1:0] rf_wp, rf_rp;
  logic [LW-1:0] rf_cnt;
  logic [WW-1:0] pf_mem [DEPTH];
  logic [PW-1:0] pf_wp, pf_rp;
  logic [LW-1:0] pf_cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [LW-1:0] eff_lvl;
  logic rd_room, pf_has, beat_done, issue, abort, last_beat;
  logic rf_push, rf_pop, pf_push, pf_pop;

  assign eff_lvl   = (rd_lvl_i == '0 || rd_lvl_i > LW'(DEPTH)) ? LW'(DEPTH) : rd_lvl_i;
  assign rd_room   = rf_cnt < eff_lvl;
  assign pf_has    = pf_cnt != '0;
  assign last_beat = left_q == '0;
  assign abort     = req_q && acc_err_i;
  assign beat_done = req_q && !acc_err_i &&
                     (op_q == OP_RD ? fl_rd_done_i :
                      op_q == OP_PG ? fl_prog_done_i : fl_erase_done_i);
  assign issue     = busy_q && !req_q &&
                     (op_q == OP_RD ? rd_room : op_q == OP_PG ? pf_has : 1'b1);

  assign rf_push = beat_done && op_q == OP_RD;
  assign rf_pop  = rf_pop_i && rf_cnt != '0;
  assign pf_pop  = beat_done && op_q == OP_PG;
  assign pf_push = pf_push_i && pf_cnt != LW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      part_q <= 1'b0;
      op_q   <= OP_RD;
      addr_q <= '0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        err_q  <= 1'b0;
        op_q   <= op_e'(op_i);
        part_q <= part_i;
        addr_q <= addr_i;
        left_q <= op_i[1] ? '0 : nwords_i;
      end
    end else if (abort) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b1;
      done_q <= 1'b1;
    end else if (beat_done) begin
      req_q  <= 1'b0;
      addr_q <= addr_q + 1'b1;
      left_q <= left_q - 1'b1;
      if (last_beat) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else if (issue) begin
      req_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rf_push) rf_mem[rf_wp] <= fl_rd_data_i;
    if (pf_push) pf_mem[pf_wp] <= pf_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_wp  <= '0;
      rf_rp  <= '0;
      rf_cnt <= '0;
      pf_wp  <= '0;
      pf_rp  <= '0;
      pf_cnt <= '0;
    end else begin
      if (rf_push) rf_wp <= nxt(rf_wp);
      if (rf_pop)  rf_rp <= nxt(rf_rp);
      rf_cnt <= rf_cnt + LW'(rf_push) - LW'(rf_pop);
      if (pf_push) pf_wp <= nxt(pf_wp);
      if (pf_pop)  pf_rp <= nxt(pf_rp);
      pf_cnt <= pf_cnt + LW'(pf_push) - LW'(pf_pop);
    end
  end

  assign busy_o           = busy_q;
  assign op_done_o        = done_q;
  assign op_err_o         = err_q;
  assign irq_rd_lvl_o     = busy_q && op_q == OP_RD && !req_q && !rd_room;
  assign irq_prog_empty_o = busy_q && op_q == OP_PG && !req_q && !pf_has;

  assign rf_rdata_o = rf_mem[rf_rp];
  assign rf_empty_o = rf_cnt == '0;
  assign rf_level_o = rf_cnt;
  assign pf_full_o  = pf_cnt == LW'(DEPTH);

  assign fl_req_o       = req_q;
  assign fl_rd_o        = req_q && op_q == OP_RD;
  assign fl_prog_o      = req_q && op_q == OP_PG;
  assign fl_pg_erase_o  = req_q && op_q == OP_PE;
  assign fl_bk_erase_o  = req_q && op_q == OP_BE;
  assign fl_part_o      = part_q;
  assign fl_addr_o      = addr_q;
  assign fl_prog_data_o = pf_mem[pf_rp];
  assign fl_prog_last_o = fl_prog_o && last_beat;

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk #(
  parameter int AW    = 16,
  parameter int WW    = 32,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          op_done_o,
  input logic          op_err_o,
  input logic [LW-1:0] rf_level_o,
  input logic          fl_req_o,
  input logic          fl_rd_o,
  input logic          fl_prog_o,
  input logic          fl_pg_erase_o,
  input logic          fl_bk_erase_o,
  input logic          fl_part_o,
  input logic [AW-1:0] fl_addr_o,
  input logic [WW-1:0] fl_prog_data_o,
  input logic          fl_prog_last_o,
  input logic          fl_rd_done_i,
  input logic          fl_prog_done_i,
  input logic          fl_erase_done_i,
  input logic          acc_err_i
);

  logic any_done;
  assign any_done = fl_rd_done_i || fl_prog_done_i || fl_erase_done_i || acc_err_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !any_done) |=> (fl_req_o && $stable(fl_addr_o) && $stable(fl_part_o) &&
      $stable({fl_rd_o, fl_prog_o, fl_pg_erase_o, fl_bk_erase_o}))); // R5

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_prog_o && !fl_prog_done_i && !acc_err_i) |=> $stable(fl_prog_data_o)); // R5

  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> $onehot({fl_rd_o, fl_prog_o, fl_pg_erase_o, fl_bk_erase_o})); // R9

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_o |-> !busy_o); // R8

  AST_ERR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && acc_err_i) |=> (!busy_o && !fl_req_o && op_err_o && op_done_o)); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_level_o <= LW'(DEPTH)); // R3

  AST_LAST_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_prog_last_o |-> fl_prog_o); // R7

endmodule

bind flash_op_seq flash_op_seq_chk #(.AW(AW), .WW(WW), .DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .op_done_o(op_done_o),
  .op_err_o(op_err_o), .rf_level_o(rf_level_o), .fl_req_o(fl_req_o),
  .fl_rd_o(fl_rd_o), .fl_prog_o(fl_prog_o), .fl_pg_erase_o(fl_pg_erase_o),
  .fl_bk_erase_o(fl_bk_erase_o), .fl_part_o(fl_part_o), .fl_addr_o(fl_addr_o),
  .fl_prog_data_o(fl_prog_data_o), .fl_prog_last_o(fl_prog_last_o),
  .fl_rd_done_i(fl_rd_done_i), .fl_prog_done_i(fl_prog_done_i),
  .fl_erase_done_i(fl_erase_done_i), .acc_err_i(acc_err_i)
);

// File: tb/flash_op_seq_tb_top.sv
module flash_op_seq_tb_top;
  localparam int AW = 16, WW = 32, CW = 12, DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          start_i = 0, part_i = 0;
  logic [1:0]    op_i = 0;
  logic [AW-1:0] addr_i = 0;
  logic [CW-1:0] nwords_i = 0;
  logic [LW-1:0] rd_lvl_i = 0;
  logic          busy_o, op_done_o, op_err_o, irq_rd_lvl_o, irq_prog_empty_o;
  logic          rf_pop_i = 0, rf_empty_o, pf_push_i = 0, pf_full_o;
  logic [WW-1:0] rf_rdata_o, pf_wdata_i = 0, fl_prog_data_o, fl_rd_data_i = 0;
  logic [LW-1:0] rf_level_o;
  logic          fl_req_o, fl_rd_o, fl_prog_o, fl_pg_erase_o, fl_bk_erase_o, fl_part_o, fl_prog_last_o;
  logic [AW-1:0] fl_addr_o;
  logic          fl_rd_done_i = 0, fl_prog_done_i = 0, fl_erase_done_i = 0, acc_err_i = 0;

  flash_op_seq #(.AW(AW), .WW(WW), .CW(CW), .DEPTH(DEPTH)) dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [WW-1:0] exp_rd[$];
  logic [WW-1:0] exp_pg[$];
  logic [AW-1:0] exp_addr;
  logic [1:0]    exp_op;
  logic          exp_part;
  int beats, total, err_beat = -1, lat = 2;
  bit drain_en = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [WW-1:0] mkdat(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  // responder and request scoreboard
  initial forever begin
    @(negedge clk_i);
    if (fl_req_o && rst_ni) begin
      logic [AW-1:0] a;
      logic [WW-1:0] d;
      a = fl_addr_o;
      d = fl_prog_data_o;
      chk(a == exp_addr, "R6 address", a, exp_addr);
      chk(fl_part_o == exp_part, "R9 partition", fl_part_o, exp_part);
      chk({fl_rd_o, fl_prog_o, fl_pg_erase_o, fl_bk_erase_o} == (4'b1000 >> exp_op),
          "R9 command", {fl_rd_o, fl_prog_o, fl_pg_erase_o, fl_bk_erase_o}, 4'b1000 >> exp_op);
      if (fl_prog_o) begin
        chk(exp_pg.size() > 0 && d == exp_pg[0], "R4 program data", d, exp_pg.size() > 0 ? exp_pg[0] : 0);
        chk(fl_prog_last_o == (beats == total - 1), "R7 last beat", fl_prog_last_o, beats == total - 1);
      end
      for (int i = 0; i < lat; i++) begin
        @(negedge clk_i);
        chk(fl_req_o && fl_addr_o == a && (!fl_prog_o || fl_prog_data_o == d), "R5 hold", fl_addr_o, a);
      end
      if (beats == err_beat) begin
        acc_err_i = 1;
        @(negedge clk_i);
        acc_err_i = 0;
      end else begin
        if (fl_rd_o) begin
          fl_rd_data_i = mkdat(a);
          exp_rd.push_back(mkdat(a));
          fl_rd_done_i = 1;
        end else if (fl_prog_o) begin
          if (exp_pg.size() > 0) void'(exp_pg.pop_front());
          fl_prog_done_i = 1;
        end else begin
          fl_erase_done_i = 1;
        end
        @(negedge clk_i);
        fl_rd_done_i = 0; fl_prog_done_i = 0; fl_erase_done_i = 0;
        exp_addr = exp_addr + 1'b1;
        beats++;
      end
    end
  end

  // read FIFO monitor
  initial forever begin
    @(negedge clk_i);
    rf_pop_i = 0;
    if (drain_en && !rf_empty_o) begin
      chk(exp_rd.size() > 0 && rf_rdata_o == exp_rd[0], "R2 read data", rf_rdata_o,
          exp_rd.size() > 0 ? exp_rd[0] : 0);
      if (exp_rd.size() > 0) void'(exp_rd.pop_front());
      rf_pop_i = 1;
    end
  end

  task automatic start_op(input logic [1:0] op, input logic part, input logic [AW-1:0] a, input int n);
    @(negedge clk_i);
    exp_op = op; exp_part = part; exp_addr = a; beats = 0; total = n;
    op_i = op; part_i = part; addr_i = a; nwords_i = CW'(n - 1);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic push_words(input int n, input logic [WW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      pf_push_i = 1;
      pf_wdata_i = base + WW'(i);
      exp_pg.push_back(base + WW'(i));
    end
    @(negedge clk_i);
    pf_push_i = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !op_done_o; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !op_done_o && !op_err_o && !fl_req_o && rf_empty_o && !irq_rd_lvl_o && !irq_prog_empty_o,
        "R1 reset state", {busy_o, op_done_o, op_err_o, fl_req_o, rf_empty_o}, 5'b00001);

    // plain read, default fill level
    drain_en = 1; lat = 2; rd_lvl_i = 0;
    start_op(2'd0, 1'b0, 16'h0020, 3);
    chk(busy_o && !op_done_o, "R8 busy after start", busy_o, 1);
    wait_done();
    chk(op_done_o && !busy_o && !op_err_o, "R8 done", {op_done_o, busy_o}, 2'b10);
    repeat (6) @(negedge clk_i);
    chk(beats == 3, "R2 beat count", beats, 3);
    chk(exp_rd.size() == 0, "R2 all words drained", exp_rd.size(), 0);

    // long read with a low fill level and no draining
    drain_en = 0; lat = 1; rd_lvl_i = 2;
    start_op(2'd0, 1'b1, 16'h0100, 8);
    for (int i = 0; i < 200 && !irq_rd_lvl_o; i++) @(negedge clk_i);
    chk(irq_rd_lvl_o, "R3 level interrupt", irq_rd_lvl_o, 1);
    chk(rf_level_o == 2, "R3 paused at fill level", rf_level_o, 2);
    // start while busy
    op_i = 2'd1; addr_i = 16'h0300; nwords_i = 0; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(!fl_req_o, "R3 no request while paused", fl_req_o, 0);
    end
    chk(busy_o && beats == 2, "R10 start ignored while busy", beats, 2);
    drain_en = 1;
    wait_done();
    repeat (6) @(negedge clk_i);
    chk(beats == 8 && exp_rd.size() == 0, "R3 resumed to full count", beats, 8);
    chk(!op_err_o, "R10 original read finished clean", op_err_o, 0);

    // program larger than the FIFO with a stall
    lat = 2;
    push_words(2, 32'hAB00_0000);
    start_op(2'd1, 1'b1, 16'h0040, 6);
    for (int i = 0; i < 200 && !irq_prog_empty_o; i++) @(negedge clk_i);
    chk(irq_prog_empty_o && !fl_req_o, "R4 empty stall interrupt", irq_prog_empty_o, 1);
    chk(beats == 2, "R4 beats before stall", beats, 2);
    push_words(4, 32'hAB00_0010);
    wait_done();
    chk(op_done_o && beats == 6 && exp_pg.size() == 0, "R4 program complete", beats, 6);

    // erases
    start_op(2'd2, 1'b0, 16'h0080, 1);
    wait_done();
    chk(op_done_o && beats == 1, "R9 page erase single request", beats, 1);
    start_op(2'd3, 1'b1, 16'h0000, 1);
    wait_done();
    chk(op_done_o && beats == 1, "R9 bank erase single request", beats, 1);

    // access error aborts
    err_beat = 2;
    start_op(2'd0, 1'b0, 16'h0200, 5);
    wait_done();
    chk(op_err_o && op_done_o && !busy_o, "R11 error status", {op_err_o, op_done_o, busy_o}, 3'b110);
    chk(beats == 2, "R11 stopped at error", beats, 2);
    repeat (6) @(negedge clk_i);
    chk(!fl_req_o && exp_rd.size() == 0 && rf_empty_o, "R11 no further requests or words", fl_req_o, 0);
    err_beat = -1;

    start_op(2'd0, 1'b0, 16'h0210, 1);
    chk(!op_err_o && !op_done_o, "R8 status cleared on start", {op_err_o, op_done_o}, 0);
    wait_done();
    repeat (6) @(negedge clk_i);
    chk(beats == 1 && exp_rd.size() == 0, "R2 single word read", beats, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule